// File: doc/BRIEF.md
# Two-Region Register Slave with Error Sideband

This block is the AXI4-Lite slave front end of a register bank. The bank has two regions: a configuration region in the lower half of the address space and a calendar region in the upper half. The slave takes write and read transactions on a single clock. It stores accepted write data in the selected register and returns one write response for every accepted write.

Write responses that the master has not yet collected are held in a small pending queue of depth `RESP_DEPTH`. When that queue is full, the slave stops accepting any new read or write until the master takes at least one response.

Failed accesses are sorted by cause on an 8-bit sideband vector. Bit 0 is a level that shows the queue is full. Bits 1 to 3 are one-cycle pulses that report failed configuration writes, failed calendar writes and accesses to addresses that hold no register.

Top module: `regbank_axil_slave`

## Requirements
- R1: `s_bvalid` is high exactly while at least one write response is pending. Each rising edge with `s_bvalid` and `s_bready` both high removes exactly one response. Responses leave in the order their writes were accepted.
- R2: The pending count rises by one on each accepted write and falls by one on each B handshake. An accepted write and a B handshake on the same edge leave the count unchanged. `err_vec[0]` is high exactly while the count equals `RESP_DEPTH`.
- R3: While `err_vec[0]` is high, `s_awready`, `s_wready` and `s_arready` are all low, so no write or read is accepted.
- R4: `s_bresp` is 2'b00 (OKAY) for a write that updated its register and 2'b10 (SLVERR) for any other accepted write. It stays stable while `s_bvalid` is high and `s_bready` is low.
- R5: A write to a mapped configuration register with `s_wstrb` not all ones leaves the register unchanged, answers SLVERR, and makes `err_vec[1]` high for the single cycle after the accepting edge.
- R6: A write to a mapped calendar register with `s_wstrb` not all ones leaves the register unchanged, answers SLVERR, and makes `err_vec[2]` high for the single cycle after the accepting edge.
- R7: A read or write whose word offset is at or above the region's register count (`CFG_COUNT` or `CAL_COUNT`) is unmapped. It makes `err_vec[3]` high for the single cycle after the accepting edge and writes nothing. A write answers SLVERR. A read returns `s_rdata` = 0 and `s_rresp` = 2'b10. An unmapped write raises only bit 3.
- R8: `err_vec[7:4]` is always zero.
- R9: Address bit `ADDR_W-1` selects the region (0 = configuration, 1 = calendar). Bits `ADDR_W-2:2` give the word offset, and bits 1:0 are ignored. A read of a mapped register returns the last value written to it with full strobes (zero after reset), with `s_rresp` = 2'b00.
- R10: While `rst` (synchronous, active high) is high, and in the first cycle after it falls, the pending count is zero. In those cycles `s_bvalid`, `s_rvalid` and `err_vec` are low, and every register reads as zero. While `rst` is high all ready outputs are low.
- R11: At most one read is outstanding. `s_arready` is low while `s_rvalid` is high. While `s_rvalid` is high and `s_rready` is low, `s_rvalid`, `s_rdata` and `s_rresp` hold. Read data appears in the cycle after the AR handshake.
- R12: Write address and write data are accepted together. `s_awready` equals `s_wready`, and both are high only when `s_awvalid` and `s_wvalid` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| err_vec | output | 8 | Error sideband: queue full, configuration write fault, calendar write fault, unmapped access, four reserved zeros |

## Verification
The bench builds the slave with `ADDR_W` = 6, `CFG_COUNT` = 5, `CAL_COUNT` = 3 and `RESP_DEPTH` = 3. With these values each region has eight word slots but fewer real registers, so unmapped offsets in both regions are only a few addresses away. The pending queue also fills after three uncollected writes, which lets the bench reach the stall, release one response, fill the queue again, and then meet a write and a collection on the same edge, all within a short run.

// File: rtl/rb_axil_pkg.sv
package rb_axil_pkg;

    localparam int ERR_W    = 8;
    localparam int ERR_FULL = 0;
    localparam int ERR_CFG  = 1;
    localparam int ERR_CAL  = 2;
    localparam int ERR_MAP  = 3;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_e;

    typedef enum logic {
        RGN_CFG = 1'b0,
        RGN_CAL = 1'b1
    } region_e;

    typedef struct packed {
        logic unmapped;
        logic cal_fail;
        logic cfg_fail;
    } fault_t;

    function automatic resp_e resp_from(input logic fail);
        return fail ? RESP_SLVERR : RESP_OKAY;
    endfunction

    function automatic logic [ERR_W-1:0] pack_err(input logic full, input fault_t f);
        logic [ERR_W-1:0] e;
        e           = '0;
        e[ERR_FULL] = full;
        e[ERR_CFG]  = f.cfg_fail;
        e[ERR_CAL]  = f.cal_fail;
        e[ERR_MAP]  = f.unmapped;
        return e;
    endfunction

endpackage

// File: rtl/rb_addr_decode.sv
module rb_addr_decode
    import rb_axil_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int CFG_COUNT = 32,
    parameter int CAL_COUNT = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ADDR_W-4:0] offset,
    output logic              mapped
);
    localparam int OFF_W = ADDR_W - 3;
    localparam logic [OFF_W:0] CFG_LIM = (OFF_W+1)'(CFG_COUNT);
    localparam logic [OFF_W:0] CAL_LIM = (OFF_W+1)'(CAL_COUNT);

    logic unused_lsbs;
    assign unused_lsbs = ^addr[1:0];

    assign region = region_e'(addr[ADDR_W-1]);
    assign offset = addr[ADDR_W-2:2];
    assign mapped = ({1'b0, offset} < ((region == RGN_CFG) ? CFG_LIM : CAL_LIM));
endmodule

// File: rtl/rb_resp_queue.sv
module rb_resp_queue #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             push_err,
    input  logic             pop,
    output logic [CNT_W-1:0] count,
    output logic             head_err
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             err_mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            err_mem[wr_ptr] <= push_err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_err = err_mem[rd_ptr];
endmodule

// File: rtl/rb_reg_store.sv
module rb_reg_store
    import rb_axil_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int OFF_W     = 7,
    parameter int CFG_COUNT = 32,
    parameter int CAL_COUNT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  region_e           w_region,
    input  logic [OFF_W-1:0]  w_off,
    input  logic [DATA_W-1:0] w_data,
    input  region_e           r_region,
    input  logic [OFF_W-1:0]  r_off,
    output logic [DATA_W-1:0] r_data
);
    logic [DATA_W-1:0] cfg_q [CFG_COUNT];
    logic [DATA_W-1:0] cal_q [CAL_COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_COUNT; i++) cfg_q[i] <= '0;
        end else if (we && w_region == RGN_CFG) begin
            for (int i = 0; i < CFG_COUNT; i++) begin
                if (w_off == OFF_W'(i)) cfg_q[i] <= w_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CAL_COUNT; i++) cal_q[i] <= '0;
        end else if (we && w_region == RGN_CAL) begin
            for (int i = 0; i < CAL_COUNT; i++) begin
                if (w_off == OFF_W'(i)) cal_q[i] <= w_data;
            end
        end
    end

    always_comb begin
        r_data = '0;
        if (r_region == RGN_CFG) begin
            for (int i = 0; i < CFG_COUNT; i++) begin
                if (r_off == OFF_W'(i)) r_data = cfg_q[i];
            end
        end else begin
            for (int i = 0; i < CAL_COUNT; i++) begin
                if (r_off == OFF_W'(i)) r_data = cal_q[i];
            end
        end
    end
endmodule

// File: rtl/regbank_axil_slave.sv
module regbank_axil_slave
    import rb_axil_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int CFG_COUNT  = 32,
    parameter int CAL_COUNT  = 64,
    parameter int RESP_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [ERR_W-1:0]    err_vec
);
    localparam int OFF_W  = ADDR_W - 3;
    localparam int STRB_W = DATA_W / 8;
    localparam int CNT_W  = $clog2(RESP_DEPTH + 1);

    logic [CNT_W-1:0]  pend_cnt;
    logic              pend_full;
    logic              head_err;
    region_e           w_rgn, r_rgn;
    logic [OFF_W-1:0]  w_off, r_off;
    logic              w_map, r_map;
    logic              aw_fire, ar_fire, b_fire;
    logic              w_partial, w_fail;
    fault_t            fault_d, fault_q;
    logic [DATA_W-1:0] store_rdata;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    resp_e             rresp_q;

    rb_addr_decode #(
        .ADDR_W(ADDR_W), .CFG_COUNT(CFG_COUNT), .CAL_COUNT(CAL_COUNT)
    ) u_wdec (
        .addr(s_awaddr), .region(w_rgn), .offset(w_off), .mapped(w_map)
    );

    rb_addr_decode #(
        .ADDR_W(ADDR_W), .CFG_COUNT(CFG_COUNT), .CAL_COUNT(CAL_COUNT)
    ) u_rdec (
        .addr(s_araddr), .region(r_rgn), .offset(r_off), .mapped(r_map)
    );

    // Pending write responses and back-pressure
    assign pend_full = (pend_cnt == CNT_W'(RESP_DEPTH));
    assign s_bvalid  = (pend_cnt != '0);
    assign b_fire    = s_bvalid && s_bready;

    // Address and data are taken in the same cycle
    assign s_awready = !rst && !pend_full && s_awvalid && s_wvalid;
    assign s_wready  = s_awready;
    assign aw_fire   = s_awready;

    assign w_partial = (s_wstrb != {STRB_W{1'b1}});
    assign w_fail    = !w_map || w_partial;

    rb_resp_queue #(
        .DEPTH(RESP_DEPTH), .CNT_W(CNT_W)
    ) u_respq (
        .clk(clk), .rst(rst), .push(aw_fire), .push_err(w_fail),
        .pop(b_fire), .count(pend_cnt), .head_err(head_err)
    );

    assign s_bresp = resp_from(head_err);

    rb_reg_store #(
        .DATA_W(DATA_W), .OFF_W(OFF_W), .CFG_COUNT(CFG_COUNT), .CAL_COUNT(CAL_COUNT)
    ) u_store (
        .clk(clk), .rst(rst), .we(aw_fire && !w_fail),
        .w_region(w_rgn), .w_off(w_off), .w_data(s_wdata),
        .r_region(r_rgn), .r_off(r_off), .r_data(store_rdata)
    );

    // Read channel: one outstanding read
    assign s_arready = !rst && !pend_full && !rvalid_q;
    assign ar_fire   = s_arvalid && s_arready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
            rresp_q  <= RESP_OKAY;
        end else if (ar_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= r_map ? store_rdata : '0;
            rresp_q  <= resp_from(!r_map);
        end else if (rvalid_q && s_rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign s_rvalid = rvalid_q;
    assign s_rdata  = rdata_q;
    assign s_rresp  = rresp_q;

    // Fault classification, registered into one-cycle pulses
    always_comb begin
        fault_d          = '0;
        fault_d.unmapped = (aw_fire && !w_map) || (ar_fire && !r_map);
        fault_d.cfg_fail = aw_fire && w_map && w_partial && (w_rgn == RGN_CFG);
        fault_d.cal_fail = aw_fire && w_map && w_partial && (w_rgn == RGN_CAL);
    end

    always_ff @(posedge clk) begin
        if (rst) fault_q <= '0;
        else     fault_q <= fault_d;
    end

    assign err_vec = pack_err(pend_full, fault_q);
endmodule

// File: rtl/rb_axil_checker.sv
module rb_axil_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              awvalid,
    input logic              wvalid,
    input logic              awready,
    input logic              wready,
    input logic              arvalid,
    input logic              arready,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic [7:0]        err_vec,
    input logic [CNT_W-1:0]  pend
);
    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        err_vec[0] |-> (!awready && !wready && !arready)); // R3

    AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (rst)
        err_vec[7:4] == 4'b0000); // R8

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
        (awvalid && awready && !(bvalid && bready)) |=> (pend == $past(pend) + CNT_W'(1))); // R2

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (bvalid && bready && !(awvalid && awready)) |=> (pend == $past(pend) - CNT_W'(1))); // R2

    AST_COUNT_HOLD_BOTH: assert property (@(posedge clk) disable iff (rst)
        (bvalid && bready && awvalid && awready) |=> $stable(pend)); // R2

    AST_BVALID_PENDING: assert property (@(posedge clk) disable iff (rst)
        bvalid == (pend != '0)); // R1

    AST_BRESP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> (bvalid && $stable(bresp))); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp))); // R11

    AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !arready); // R11

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (|err_vec[3:1]) |-> $past((awvalid && awready) || (arvalid && arready))); // R7

    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (rst)
        awready |-> (awvalid && wvalid && wready)); // R12
endmodule

bind regbank_axil_slave rb_axil_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_checker (
    .clk(clk), .rst(rst),
    .awvalid(s_awvalid), .wvalid(s_wvalid), .awready(s_awready), .wready(s_wready),
    .arvalid(s_arvalid), .arready(s_arready),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .err_vec(err_vec), .pend(pend_cnt)
);

// File: tb/regbank_axil_slave_test.sv
`timescale 1ns/1ps
module regbank_axil_slave_test;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int CFG_N  = 5;
    localparam int CAL_N  = 3;
    localparam int DEPTH  = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] awaddr, araddr;
    logic              awvalid, wvalid, arvalid, bready, rready;
    logic [DATA_W-1:0] wdata;
    logic [3:0]        wstrb;
    logic              s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
    logic [1:0]        s_bresp, s_rresp;
    logic [DATA_W-1:0] s_rdata;
    logic [7:0]        err_vec;

    int n_checks = 0;
    int n_err    = 0;

    always #10 clk = ~clk;

    regbank_axil_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_COUNT(CFG_N),
        .CAL_COUNT(CAL_N), .RESP_DEPTH(DEPTH)
    ) uut (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(s_awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(rready),
        .err_vec(err_vec)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] adr(input bit cal, input int off);
        return {cal, 3'(off), 2'b00};
    endfunction

    // Behavioural reference model
    bit [31:0] m_cfg [CFG_N];
    bit [31:0] m_cal [CAL_N];
    bit        mq [$];
    bit        m_rv;
    bit [31:0] m_rdata;
    bit [1:0]  m_rresp;
    bit [2:0]  m_err;

    always @(posedge clk) begin : model
        bit full, awf, arf, bf, wcal, wmap, rcal, rmap;
        int woff, roff;
        bit [2:0] e;
        if (rst) begin
            foreach (m_cfg[i]) m_cfg[i] = 0;
            foreach (m_cal[i]) m_cal[i] = 0;
            mq.delete();
            m_rv = 0; m_rdata = 0; m_rresp = 0; m_err = 0;
        end else begin
            full = (mq.size() == DEPTH);
            awf  = awvalid && wvalid && !full;
            arf  = arvalid && !full && !m_rv;
            bf   = (mq.size() > 0) && bready;
            e    = 0;
            if (m_rv && rready) m_rv = 0;
            if (arf) begin
                rcal = araddr[5];
                roff = int'(araddr[4:2]);
                rmap = roff < (rcal ? CAL_N : CFG_N);
                m_rv = 1;
                m_rdata = rmap ? (rcal ? m_cal[roff] : m_cfg[roff]) : 32'h0;
                m_rresp = rmap ? 2'b00 : 2'b10;
                if (!rmap) e[2] = 1;
            end
            if (bf) void'(mq.pop_front());
            if (awf) begin
                wcal = awaddr[5];
                woff = int'(awaddr[4:2]);
                wmap = woff < (wcal ? CAL_N : CFG_N);
                if (!wmap) begin
                    e[2] = 1; mq.push_back(1);
                end else if (wstrb != 4'hF) begin
                    if (wcal) e[1] = 1; else e[0] = 1;
                    mq.push_back(1);
                end else begin
                    if (wcal) m_cal[woff] = wdata; else m_cfg[woff] = wdata;
                    mq.push_back(0);
                end
            end
            m_err = e;
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin : compare
        bit full;
        #5;
        full = (mq.size() == DEPTH);
        chk("R12", "awready", s_awready, !rst && !full && awvalid && wvalid);
        chk("R12", "wready",  s_wready,  s_awready);
        chk("R3",  "arready", s_arready, !rst && !full && !m_rv);
        chk("R1",  "bvalid",  s_bvalid,  mq.size() > 0);
        if (mq.size() > 0) chk("R4", "bresp", s_bresp, mq[0] ? 2'b10 : 2'b00);
        chk("R11", "rvalid",  s_rvalid,  m_rv);
        if (m_rv) begin
            chk("R9", "rdata", s_rdata, m_rdata);
            chk("R9", "rresp", s_rresp, m_rresp);
        end
        chk("R2", "err full",    err_vec[0],   full);
        chk("R5", "err cfg",     err_vec[1],   m_err[0]);
        chk("R6", "err cal",     err_vec[2],   m_err[1]);
        chk("R7", "err unmap",   err_vec[3],   m_err[2]);
        chk("R8", "err reserved", err_vec[7:4], 4'h0);
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] s);
        bit got;
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        do begin
            #6 got = s_awready;
            @(negedge clk);
        end while (!got);
        awvalid = 0; wvalid = 0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        bit got;
        araddr = a; arvalid = 1;
        do begin
            #6 got = s_arready;
            @(negedge clk);
        end while (!got);
        arvalid = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : stim
        rst = 1; awaddr = 0; araddr = 0; wdata = 0; wstrb = 0;
        awvalid = 1; wvalid = 1; arvalid = 1; bready = 1; rready = 1;
        repeat (3) @(negedge clk);
        #6;
        chk("R10", "ready in reset",  {s_awready, s_wready, s_arready}, 3'b000);
        chk("R10", "bvalid in reset", s_bvalid, 1'b0);
        chk("R10", "rvalid in reset", s_rvalid, 1'b0);
        chk("R10", "err in reset",    err_vec, 8'h00);
        @(negedge clk);
        rst = 0; awvalid = 0; wvalid = 0; arvalid = 0;
        @(negedge clk);

        // Mapped reads after reset return zero
        rd(adr(1, 1));
        #6 chk("R10", "register after reset", s_rdata, 32'h0);
        @(negedge clk);

        // Full writes and readback in both regions
        wr(adr(0, 0), 32'hA5A5_0001, 4'hF);
        #6 chk("R4", "bresp okay", s_bresp, 2'b00);
        @(negedge clk);
        rd(adr(0, 0));
        #6 chk("R9", "cfg readback", s_rdata, 32'hA5A5_0001);
        chk("R9", "cfg rresp", s_rresp, 2'b00);
        @(negedge clk);
        wr(adr(1, 2), 32'h0000_CA12, 4'hF);
        rd(adr(1, 2));
        #6 chk("R9", "cal readback", s_rdata, 32'h0000_CA12);
        @(negedge clk);

        // Partial write to the configuration region
        wr(adr(0, 0), 32'hDEAD_BEEF, 4'h3);
        #6 chk("R5", "cfg fault pulse", err_vec[3:1], 3'b001);
        chk("R4", "bresp slverr", s_bresp, 2'b10);
        @(negedge clk);
        #6 chk("R5", "cfg pulse one cycle", err_vec[1], 1'b0);
        @(negedge clk);
        rd(adr(0, 0));
        #6 chk("R5", "cfg unchanged", s_rdata, 32'hA5A5_0001);
        @(negedge clk);

        // Partial write to the calendar region
        wr(adr(1, 2), 32'h0000_0001, 4'h8);
        #6 chk("R6", "cal fault pulse", err_vec[3:1], 3'b010);
        @(negedge clk);
        rd(adr(1, 2));
        #6 chk("R6", "cal unchanged", s_rdata, 32'h0000_CA12);
        @(negedge clk);

        // Unmapped write and read
        wr(adr(0, 6), 32'h0000_0077, 4'hF);
        #6 chk("R7", "unmapped write pulse", err_vec[3:1], 3'b100);
        chk("R7", "unmapped write slverr", s_bresp, 2'b10);
        @(negedge clk);
        rd(adr(0, 4));
        #6 chk("R9", "last cfg register", s_rresp, 2'b00);
        @(negedge clk);
        rd(adr(1, 4));
        #6 chk("R7", "unmapped read pulse", err_vec[3], 1'b1);
        chk("R7", "unmapped rdata", s_rdata, 32'h0);
        chk("R7", "unmapped rresp", s_rresp, 2'b10);
        @(negedge clk);
        repeat (3) @(negedge clk);

        // Fill the pending queue and stall
        bready = 0;
        wr(adr(0, 1), 32'h11, 4'hF);
        wr(adr(0, 2), 32'h22, 4'hF);
        wr(adr(0, 3), 32'h33, 4'h1);
        #6 chk("R2", "full after three", err_vec[0], 1'b1);
        @(negedge clk);
        fork
            wr(adr(0, 4), 32'h44, 4'hF);
            rd(adr(0, 1));
            begin
                repeat (3) @(negedge clk);
                #6 chk("R3", "write stalled", s_awready, 1'b0);
                chk("R3", "read stalled", s_arready, 1'b0);
                @(negedge clk);
                bready = 1;
                @(negedge clk);
                bready = 0;
            end
        join
        #6 chk("R2", "full again", err_vec[0], 1'b1);
        @(negedge clk);
        bready = 1;
        repeat (5) @(negedge clk);
        #6 chk("R1", "drained", s_bvalid, 1'b0);
        @(negedge clk);

        // Write and collection on the same edge
        bready = 0;
        wr(adr(1, 0), 32'h55, 4'hF);
        wr(adr(1, 1), 32'h66, 4'hF);
        bready = 1;
        wr(adr(1, 0), 32'h77, 4'hF);
        bready = 0;
        #6 chk("R2", "count held at two", s_bvalid, 1'b1);
        @(negedge clk);
        bready = 1;
        @(negedge clk);
        #6 chk("R2", "one left", s_bvalid, 1'b1);
        @(negedge clk);
        bready = 0;
        #6 chk("R2", "none left", s_bvalid, 1'b0);
        @(negedge clk);
        bready = 1;

        // Read data held while not taken
        rready = 0;
        rd(adr(1, 0));
        repeat (3) @(negedge clk);
        #6 chk("R11", "rvalid held", s_rvalid, 1'b1);
        chk("R11", "rdata held", s_rdata, 32'h77);
        chk("R11", "no second read", s_arready, 1'b0);
        @(negedge clk);
        rready = 1;
        @(negedge clk);
        #6 chk("R11", "rvalid cleared", s_rvalid, 1'b0);
        @(negedge clk);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule